// File: doc/BRIEF.md
# Cache Touch Prefetch Controller

This block handles software prefetch hints ("touches") aimed at a two-level data cache. A touch names an address and says whether the program means to load from the line or to store into it. A write-through attribute also comes with each touch. The controller probes the first-level and second-level tag arrays through combinational lookup ports, then takes one of four actions:

- do nothing;
- refresh the replacement information of a line that is already resident;
- copy a line from the second level into the first;
- request a fill from the system bus.

At most one bus fill is in flight at a time. While it is outstanding, new touches are held off through the request handshake. A store to the line being filled is told to stall until the reload into the first level has happened. Every line that a touch brings into the first level is marked so that store-miss merging leaves it alone.

Top module: `touch_prefetch_ctrl`

## Requirements
- R1: A store-intent touch with the write-through attribute set is accepted as a no-op. It raises no lookup, no bus request, no install and no reference update.
- R2: A store-intent or load-intent touch that hits in L1 causes no install and no bus request. One cycle after acceptance it raises a single reference/replacement update for the line.
- R3: A touch that misses L1 and hits L2 installs the line in L1 one cycle after acceptance. The installed state equals the L2 state, encoded as 0 invalid, 1 shared, 2 exclusive, 3 modified. No bus request is made.
- R4: A store-intent touch that misses both levels issues a bus request one cycle after acceptance. The request type is 2 (intent-to-modify read) when the bus-mode input is 0 and 3 (read-claim) when it is 1. When the fill completes, the line is installed as exclusive (2) whatever the bus response.
- R5: A load-intent touch that misses both levels issues a bus request of type 1 (plain read). When the fill completes, the line is installed as shared (1) if the bus reports sharing and as exclusive (2) otherwise.
- R6: Every install carries a reference/replacement update for the same line in the same cycle.
- R7: Every line installed by this block has its no-merge flag set.
- R8: A store whose line equals the line of the outstanding fill sees the stall output high. The stall drops in the cycle the fill is installed. A store to any other line never stalls.
- R9: While a fill is outstanding, request-ready is low and no lookup is made. A completion pulse that arrives with no fill outstanding has no effect.
- R10: Lookup, bus, install and reference addresses, and the stall comparison, all use the line address, which is the address with its low 5 bits cleared.
- R11: After reset, request-ready is high, and the stall, bus request, install and reference outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Touch request valid |
| req_ready | output | 1 | Touch request can be accepted |
| req_addr | input | AW | Touch byte address |
| req_store | input | 1 | 1 = store intent, 0 = load intent |
| req_wt | input | 1 | Write-through attribute of the target |
| bus_mode | input | 1 | Store-intent request encoding select |
| lk_addr | output | AW | Line address presented to both tag probes |
| l1_lk_valid | output | 1 | L1 probe strobe |
| l1_hit | input | 1 | L1 probe hit |
| l2_lk_valid | output | 1 | L2 probe strobe |
| l2_hit | input | 1 | L2 probe hit |
| l2_state | input | 2 | Coherency state of the L2 line |
| bus_req_valid | output | 1 | Bus fill request pulse |
| bus_req_type | output | 2 | 1 read, 2 intent-to-modify, 3 read-claim |
| bus_req_addr | output | AW | Line address of the fill |
| bus_fill_done | input | 1 | Fill data delivered |
| bus_fill_shared | input | 1 | Bus reported other sharers |
| inst_valid | output | 1 | Install line into L1 |
| inst_addr | output | AW | Installed line address |
| inst_state | output | 2 | Installed coherency state |
| inst_no_merge | output | 1 | Exclude line from store-miss merging |
| ref_valid | output | 1 | Set reference bit / update pseudo-LRU |
| ref_addr | output | AW | Line for the reference update |
| st_valid | input | 1 | Store probe valid |
| st_addr | input | AW | Store byte address |
| st_stall | output | 1 | Store must wait for the outstanding fill |

## Verification
The outstanding-fill record is the state that matters. If the record is lost, req_ready comes back early and the store stall drops before the install, one cycle after the request. If the record sticks, req_ready stays low and the stall persists after the install pulse. A wrong remembered intent or line shows up only at completion, as a wrong install state or address. A decision fault shows up one cycle after acceptance, as a wrong bus type or a missing or extra install.

// File: rtl/touch_pkg.sv
package touch_pkg;
    typedef enum logic [1:0] {
        CS_INV = 2'd0,
        CS_SHR = 2'd1,
        CS_EXC = 2'd2,
        CS_MOD = 2'd3
    } coh_t;

    typedef enum logic [1:0] {
        BR_NONE  = 2'd0,
        BR_READ  = 2'd1,
        BR_RWITM = 2'd2,
        BR_CLAIM = 2'd3
    } breq_t;

    typedef enum logic [1:0] {
        ACT_NOOP = 2'd0,
        ACT_REF  = 2'd1,
        ACT_COPY = 2'd2,
        ACT_FILL = 2'd3
    } act_t;
endpackage

// File: rtl/tp_decide.sv
module tp_decide
    import touch_pkg::*;
(
    input  logic  store_i,
    input  logic  wt_i,
    input  logic  l1_hit_i,
    input  logic  l2_hit_i,
    input  logic  mode_i,
    output act_t  act_o,
    output breq_t btype_o
);
    always_comb begin
        act_o   = ACT_NOOP;
        btype_o = BR_NONE;
        if (store_i && wt_i) begin
            act_o = ACT_NOOP;
        end else if (l1_hit_i) begin
            act_o = ACT_REF;
        end else if (l2_hit_i) begin
            act_o = ACT_COPY;
        end else begin
            act_o = ACT_FILL;
            if (!store_i)    btype_o = BR_READ;
            else if (mode_i) btype_o = BR_CLAIM;
            else             btype_o = BR_RWITM;
        end
    end
endmodule

// File: rtl/tp_line_match.sv
module tp_line_match #(
    parameter int AW     = 32,
    parameter int OFF_W  = 5
) (
    input  logic          en_i,
    input  logic [AW-1:0] addr_i,
    input  logic [AW-1:0] line_i,
    output logic          hit_o
);
    localparam logic [AW-1:0] LMASK = ~((AW'(1) << OFF_W) - AW'(1));

    always_comb hit_o = en_i && ((addr_i & LMASK) == line_i);
endmodule

// File: rtl/touch_prefetch_ctrl.sv
module touch_prefetch_ctrl
    import touch_pkg::*;
#(
    parameter int AW         = 32,
    parameter int LINE_BYTES = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic          req_store,
    input  logic          req_wt,
    input  logic          bus_mode,
    output logic [AW-1:0] lk_addr,
    output logic          l1_lk_valid,
    input  logic          l1_hit,
    output logic          l2_lk_valid,
    input  logic          l2_hit,
    input  logic [1:0]    l2_state,
    output logic          bus_req_valid,
    output logic [1:0]    bus_req_type,
    output logic [AW-1:0] bus_req_addr,
    input  logic          bus_fill_done,
    input  logic          bus_fill_shared,
    output logic          inst_valid,
    output logic [AW-1:0] inst_addr,
    output logic [1:0]    inst_state,
    output logic          inst_no_merge,
    output logic          ref_valid,
    output logic [AW-1:0] ref_addr,
    input  logic          st_valid,
    input  logic [AW-1:0] st_addr,
    output logic          st_stall
);
    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam logic [AW-1:0] LMASK = ~((AW'(1) << OFF_W) - AW'(1));

    typedef struct packed {
        logic          pend;
        logic          pend_st;
        logic [AW-1:0] line;
        logic          breq_v;
        logic [1:0]    breq_t;
        logic          inst_v;
        logic [1:0]    inst_st;
        logic [AW-1:0] inst_a;
        logic          ref_v;
        logic [AW-1:0] ref_a;
    } regs_t;

    regs_t r_q, r_d;

    logic          accept;
    logic [AW-1:0] req_line;
    act_t          act;
    breq_t         btype;

    assign req_line = req_addr & LMASK;
    assign accept   = req_valid && !r_q.pend;

    tp_decide u_decide (
        .store_i  (req_store),
        .wt_i     (req_wt),
        .l1_hit_i (l1_hit),
        .l2_hit_i (l2_hit),
        .mode_i   (bus_mode),
        .act_o    (act),
        .btype_o  (btype)
    );

    tp_line_match #(.AW(AW), .OFF_W(OFF_W)) u_stall_cmp (
        .en_i   (st_valid && r_q.pend),
        .addr_i (st_addr),
        .line_i (r_q.line),
        .hit_o  (st_stall)
    );

    always_comb begin
        r_d        = r_q;
        r_d.breq_v = 1'b0;
        r_d.inst_v = 1'b0;
        r_d.ref_v  = 1'b0;
        if (accept) begin
            case (act)
                ACT_REF: begin
                    r_d.ref_v = 1'b1;
                    r_d.ref_a = req_line;
                end
                ACT_COPY: begin
                    r_d.inst_v  = 1'b1;
                    r_d.inst_st = l2_state;
                    r_d.inst_a  = req_line;
                    r_d.ref_v   = 1'b1;
                    r_d.ref_a   = req_line;
                end
                ACT_FILL: begin
                    r_d.pend    = 1'b1;
                    r_d.pend_st = req_store;
                    r_d.line    = req_line;
                    r_d.breq_v  = 1'b1;
                    r_d.breq_t  = btype;
                end
                default: ;
            endcase
        end else if (r_q.pend && bus_fill_done) begin
            r_d.pend    = 1'b0;
            r_d.inst_v  = 1'b1;
            r_d.inst_a  = r_q.line;
            r_d.inst_st = (r_q.pend_st || !bus_fill_shared) ? CS_EXC : CS_SHR;
            r_d.ref_v   = 1'b1;
            r_d.ref_a   = r_q.line;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign req_ready     = !r_q.pend;
    assign lk_addr       = req_line;
    assign l1_lk_valid   = accept && !(req_store && req_wt);
    assign l2_lk_valid   = l1_lk_valid && !l1_hit;
    assign bus_req_valid = r_q.breq_v;
    assign bus_req_type  = r_q.breq_t;
    assign bus_req_addr  = r_q.line;
    assign inst_valid    = r_q.inst_v;
    assign inst_addr     = r_q.inst_a;
    assign inst_state    = r_q.inst_st;
    assign inst_no_merge = r_q.inst_v;
    assign ref_valid     = r_q.ref_v;
    assign ref_addr      = r_q.ref_a;
endmodule

// File: rtl/touch_prefetch_ctrl_chk.sv
module touch_prefetch_ctrl_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          req_store,
    input logic          req_wt,
    input logic          l1_lk_valid,
    input logic          l2_lk_valid,
    input logic          l1_hit,
    input logic          l2_hit,
    input logic [1:0]    l2_state,
    input logic          bus_req_valid,
    input logic [1:0]    bus_req_type,
    input logic          bus_fill_done,
    input logic          inst_valid,
    input logic [1:0]    inst_state,
    input logic [AW-1:0] inst_addr,
    input logic          ref_valid,
    input logic [AW-1:0] ref_addr,
    input logic          st_stall
);
    p_wt_noop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_store && req_wt) |=>
            (!bus_req_valid && !inst_valid && !ref_valid));

    p_wt_nolookup_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_store && req_wt) |-> !l1_lk_valid);

    p_l2_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (l2_lk_valid && l2_hit) |=> (inst_valid && inst_state == $past(l2_state)));

    p_bus_type_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid |-> (bus_req_type != 2'd0));

    p_fill_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_fill_done && !req_ready) |=> (inst_valid && req_ready));

    p_ref_with_inst_r6: assert property (@(posedge clk) disable iff (!rst_n)
        inst_valid |-> (ref_valid && ref_addr == inst_addr));

    p_stall_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_stall |-> !req_ready);

    p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid |-> (!req_ready && !l1_lk_valid));
endmodule

bind touch_prefetch_ctrl touch_prefetch_ctrl_chk #(.AW(AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_store     (req_store),
    .req_wt        (req_wt),
    .l1_lk_valid   (l1_lk_valid),
    .l2_lk_valid   (l2_lk_valid),
    .l1_hit        (l1_hit),
    .l2_hit        (l2_hit),
    .l2_state      (l2_state),
    .bus_req_valid (bus_req_valid),
    .bus_req_type  (bus_req_type),
    .bus_fill_done (bus_fill_done),
    .inst_valid    (inst_valid),
    .inst_state    (inst_state),
    .inst_addr     (inst_addr),
    .ref_valid     (ref_valid),
    .ref_addr      (ref_addr),
    .st_stall      (st_stall)
);

// File: tb/sim_touch_prefetch_ctrl.sv
module sim_touch_prefetch_ctrl;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid, req_ready, req_store, req_wt, bus_mode;
    logic [AW-1:0] req_addr, lk_addr, bus_req_addr, inst_addr, ref_addr, st_addr;
    logic          l1_lk_valid, l1_hit, l2_lk_valid, l2_hit;
    logic [1:0]    l2_state, bus_req_type, inst_state;
    logic          bus_req_valid, bus_fill_done, bus_fill_shared;
    logic          inst_valid, inst_no_merge, ref_valid, st_valid, st_stall;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    touch_prefetch_ctrl #(.AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_store(req_store), .req_wt(req_wt), .bus_mode(bus_mode),
        .lk_addr(lk_addr), .l1_lk_valid(l1_lk_valid), .l1_hit(l1_hit),
        .l2_lk_valid(l2_lk_valid), .l2_hit(l2_hit), .l2_state(l2_state),
        .bus_req_valid(bus_req_valid), .bus_req_type(bus_req_type),
        .bus_req_addr(bus_req_addr), .bus_fill_done(bus_fill_done),
        .bus_fill_shared(bus_fill_shared), .inst_valid(inst_valid),
        .inst_addr(inst_addr), .inst_state(inst_state),
        .inst_no_merge(inst_no_merge), .ref_valid(ref_valid),
        .ref_addr(ref_addr), .st_valid(st_valid), .st_addr(st_addr),
        .st_stall(st_stall)
    );

    task automatic chk(input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // [14]store [13]wt [12]l1hit [11]l2hit [10:9]l2state [8]mode [7]shared
    // [6:5]exp bus type [4]exp install now [3:2]exp state [1]exp ref now [0]exp fill
    localparam int NV = 10;
    localparam logic [14:0] VEC [0:NV-1] = '{
        15'b1_1_1_0_00_0_0_00_0_00_0_0,  // R1 store touch write-through
        15'b1_0_1_0_00_0_0_00_0_00_1_0,  // R2 store L1 hit
        15'b1_0_0_1_11_0_0_00_1_11_1_0,  // R3 store L2 hit modified
        15'b1_0_0_1_01_0_0_00_1_01_1_0,  // R3 store L2 hit shared
        15'b1_0_0_0_00_0_1_10_0_10_0_1,  // R4 store miss, mode 0
        15'b1_0_0_0_00_1_0_11_0_10_0_1,  // R4 store miss, mode 1
        15'b0_0_1_0_00_0_0_00_0_00_1_0,  // R2 load L1 hit
        15'b0_1_0_1_10_0_0_00_1_10_1_0,  // R3 load L2 hit exclusive
        15'b0_0_0_0_00_0_1_01_0_01_0_1,  // R5 load miss shared
        15'b0_0_0_0_00_1_0_01_0_10_0_1   // R5 load miss exclusive
    };

    task automatic idle_inputs();
        req_valid = 0; req_store = 0; req_wt = 0; bus_mode = 0;
        req_addr = '0; l1_hit = 0; l2_hit = 0; l2_state = 0;
        bus_fill_done = 0; bus_fill_shared = 0; st_valid = 0; st_addr = '0;
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle_inputs();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R11 reset state
        chk("R11", "ready", req_ready, 1);
        chk("R11", "stall", st_stall, 0);
        chk("R11", "bus", bus_req_valid, 0);
        chk("R11", "inst", inst_valid, 0);
        chk("R11", "ref", ref_valid, 0);

        for (int i = 0; i < NV; i++) begin
            logic [14:0]   v;
            logic [AW-1:0] a, line;
            v    = VEC[i];
            a    = 32'h1000_0000 + AW'(i) * 32'h40 + 32'h1b;
            line = a & ~32'h1f;
            @(negedge clk);
            req_valid = 1; req_addr = a; req_store = v[14]; req_wt = v[13];
            l1_hit = v[12]; l2_hit = v[11]; l2_state = v[10:9]; bus_mode = v[8];
            #1;
            chk("R9", "ready idle", req_ready, 1);
            chk("R1", "l1 lookup", l1_lk_valid, !(v[14] && v[13]));
            chk("R10", "lookup line", lk_addr, line);
            @(negedge clk);
            req_valid = 0; l1_hit = 0; l2_hit = 0;
            chk(v[0] ? "R4" : "R1", "bus valid", bus_req_valid, v[0]);
            chk(v[14] ? "R4" : "R5", "bus type", bus_req_type & {2{v[0]}}, v[6:5]);
            chk("R3", "inst now", inst_valid, v[4]);
            chk("R2", "ref now", ref_valid, v[1]);
            if (v[4]) begin
                chk("R3", "inst state", inst_state, v[3:2]);
                chk("R7", "no merge", inst_no_merge, 1);
                chk("R10", "inst line", inst_addr, line);
            end
            if (v[1]) chk("R6", "ref line", ref_addr, line);
            if (v[0]) begin
                chk("R10", "bus line", bus_req_addr, line);
                chk("R9", "ready busy", req_ready, 0);
                st_valid = 1; st_addr = line + 32'h4;
                #1;
                chk("R8", "stall same line", st_stall, 1);
                st_addr = line + 32'h20;
                #1;
                chk("R8", "no stall other line", st_stall, 0);
                st_addr = line + 32'h8;
                @(negedge clk);
                chk("R8", "stall held", st_stall, 1);
                bus_fill_done = 1; bus_fill_shared = v[7];
                @(negedge clk);
                bus_fill_done = 0;
                chk(v[14] ? "R4" : "R5", "fill state", inst_state, v[3:2]);
                chk("R5", "fill inst", inst_valid, 1);
                chk("R7", "fill no merge", inst_no_merge, 1);
                chk("R6", "fill ref", ref_valid, 1);
                chk("R6", "fill ref line", ref_addr, line);
                chk("R8", "stall released", st_stall, 0);
                chk("R9", "ready again", req_ready, 1);
                st_valid = 0;
            end
        end

        // R9: request while busy is held off, stray completion ignored
        @(negedge clk);
        bus_fill_done = 1;
        @(negedge clk);
        bus_fill_done = 0;
        chk("R9", "stray done no inst", inst_valid, 0);
        req_valid = 1; req_addr = 32'h2000_0005; req_store = 1; l1_hit = 0; l2_hit = 0;
        @(negedge clk);
        req_addr = 32'h3000_0000; l1_hit = 1;
        #1;
        chk("R9", "busy ready low", req_ready, 0);
        chk("R9", "busy no lookup", l1_lk_valid, 0);
        @(negedge clk);
        chk("R9", "busy no ref", ref_valid, 0);
        bus_fill_done = 1;
        @(negedge clk);
        bus_fill_done = 0;
        chk("R4", "directed fill inst", inst_addr, 32'h2000_0000);
        #1;
        chk("R9", "accepted after done", l1_lk_valid, 1);
        @(negedge clk);
        req_valid = 0; l1_hit = 0;
        chk("R2", "held request ref", ref_valid, 1);
        chk("R10", "held request line", ref_addr, 32'h3000_0000);

        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule